// File: doc/BRIEF.md
# Grouped Interrupt Cause Aggregator

This unit collects event pulses from three sources (transmit, receive and miscellaneous) into three 32-bit cause registers. It condenses them into a three-bit summary and drives one level-sensitive host interrupt line. Software reaches every register through a single-cycle word-addressed read/write port. Read data is combinational in the cycle the read strobe is high, and every read side effect takes place at the clock edge that ends that cycle.

Each cause bit can be released in one of two ways, chosen per bit. A read of the cause register can release it, or an explicit write of a one can release it. Each group's mask is changed only through two strobe registers: one sets mask bits and the other clears them. The summary captures which groups hold unmasked pending causes, and a read of the summary releases it. A software summary mask and an optional moderation stage sit between the summary and the host line. The moderation stage delays the line while a burst of events is still arriving.

Top module: `irq_aggregator`

Word addresses. The groups sit at base 0 (transmit), 8 (receive) and 16 (miscellaneous). Within a group, offset +0 is the cause register, +1 the clear-mode register, +2 the mask-set strobe, +3 the mask-clear strobe, +4 the mask read-back and +5 the masked view. The summary is at 24, the summary mask at 25, the moderation threshold at 26 and the moderation control at 27 (bit 0 is the enable). Unmapped reads return 0.

## Requirements
- R1: A cause bit whose clear-mode bit is 1 is cleared by the clock edge that ends a read of its group's cause register (offset +0). The read itself returns the value before the clear.
- R2: A cause bit whose clear-mode bit is 0 is not changed by reads. It is cleared only by writing a 1 to that bit position at offset +0. Ones written to bits in clear-on-read mode are ignored.
- R3: A write to offset +2 sets each mask bit written as 1. A write to offset +3 clears each mask bit written as 1. Zero bits leave the mask unchanged.
- R4: Offset +4 reads back the current mask. Offset +5 reads the cause register with masked bits forced to 0.
- R5: Summary bit 0 (transmit), bit 1 (receive) and bit 2 (miscellaneous) become 1 on the edge after the group has any cause bit that is both set and unmasked. Upper summary bits read 0.
- R6: A summary bit is sticky until the summary is read. The edge ending that read reloads the summary with the groups' current unmasked-pending state, so no acknowledge write is needed.
- R7: The summary mask (address 25) resets to all ones. A summary bit whose matching mask bit (0..2) is 1 cannot raise the host line.
- R8: With moderation disabled, `host_irq` is high exactly while some summary bit is set and unmasked in the summary mask.
- R9: With the moderation enable (address 27 bit 0) set, the line is held low after the request appears. It rises on the first edge at which either no event input is active or the count of event-carrying cycles since the request appeared has reached the threshold (address 26). Writing 0 to address 27 restores immediate behaviour.
- R10: An event on a cause bit in the same cycle as a read-clear or write-clear of that bit leaves the bit set.
- R11: After reset all mask bits are 1, all cause bits are 0, all clear-mode bits are 0, and `host_irq` is low. Events are latched even into masked bits.
- R12: Clearing the mask of an already pending cause bit sets the group's summary bit on the following edge, with no new event needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects at the edge) |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_rd is high |
| tx_evt | input | 32 | Transmit event pulses, one per cause bit |
| rx_evt | input | 32 | Receive event pulses |
| misc_evt | input | 32 | Miscellaneous event pulses |
| host_irq | output | 1 | Host interrupt line |

## Verification
The bench drives an event into a bit in the same cycle as a read-clear and as a write-clear of that bit. A design that lets the clear win would silently lose that event. It reads a cause register twice in write-one-to-clear mode, and mixed-mode bits in clear-on-read mode, to catch a design that applies one release rule to every bit. It unmasks a bit that is already pending to catch a summary that waits for a fresh edge. It also reads the summary twice to catch a design that either fails to release it or never reloads it. Under moderation it checks the exact cycle the line rises during a continuous burst, which exposes an off-by-one in the threshold compare or a line that ignores moderation altogether.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NGRP  = 3;
  localparam int GRP_TX   = 0;
  localparam int GRP_RX   = 1;
  localparam int GRP_MISC = 2;

  // offsets inside a group window (address bits [2:0])
  localparam logic [2:0] OFS_CAUSE = 3'd0;
  localparam logic [2:0] OFS_CMODE = 3'd1;
  localparam logic [2:0] OFS_MSET  = 3'd2;
  localparam logic [2:0] OFS_MCLR  = 3'd3;
  localparam logic [2:0] OFS_MASK  = 3'd4;
  localparam logic [2:0] OFS_MVIEW = 3'd5;

  // global registers
  localparam logic [4:0] ADR_SUM   = 5'd24;
  localparam logic [4:0] ADR_SMASK = 5'd25;
  localparam logic [4:0] ADR_THR   = 5'd26;
  localparam logic [4:0] ADR_MCTL  = 5'd27;
endpackage

// File: rtl/irq_cause_group.sv
module irq_cause_group #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt_i,
  input  logic          wr_cause_i,
  input  logic          rd_cause_i,
  input  logic          wr_cmode_i,
  input  logic          wr_mset_i,
  input  logic          wr_mclr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cause_o,
  output logic [DW-1:0] cmode_o,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] mview_o,
  output logic          pend_o
);
  logic [DW-1:0] cause_q, cmode_q, mask_q;
  logic [DW-1:0] clr_w;

  // bits released this cycle: explicit ones on write-one-to-clear bits,
  // and every clear-on-read bit when the cause register is read
  function automatic logic [DW-1:0] release_bits(
    input logic wr, input logic rd,
    input logic [DW-1:0] wd, input logic [DW-1:0] mode);
    logic [DW-1:0] r;
    r = '0;
    if (wr) r = r | (wd & ~mode);
    if (rd) r = r | mode;
    return r;
  endfunction

  assign clr_w = release_bits(wr_cause_i, rd_cause_i, wdata_i, cmode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      cmode_q <= '0;
      mask_q  <= '1;
    end else begin
      cause_q <= (cause_q & ~clr_w) | evt_i;   // event wins over clear
      if (wr_cmode_i) cmode_q <= wdata_i;
      if (wr_mset_i)      mask_q <= mask_q | wdata_i;
      else if (wr_mclr_i) mask_q <= mask_q & ~wdata_i;
    end
  end

  assign cause_o = cause_q;
  assign cmode_o = cmode_q;
  assign mask_o  = mask_q;
  assign mview_o = cause_q & ~mask_q;
  assign pend_o  = |mview_o;

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((cause_q & $past(evt_i)) == $past(evt_i))); // R10
  AST_COR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cause_i |=> ((cause_q & $past(cmode_q) & ~$past(evt_i)) == '0)); // R1
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mset_i |=> ((mask_q & $past(wdata_i)) == $past(wdata_i))); // R3
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mclr_i && !wr_mset_i) |=> ((mask_q & $past(wdata_i)) == '0)); // R3
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [CW-1:0] thr_i,
  input  logic          req_i,
  input  logic          evt_i,
  output logic          irq_o
);
  logic [CW-1:0] cnt_q;
  logic          rel_q;
  logic          reached_w;

  function automatic logic at_threshold(input logic [CW-1:0] c, input logic [CW-1:0] t);
    return c >= t;
  endfunction

  assign reached_w = at_threshold(cnt_q, thr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (!req_i) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else begin
      if (evt_i && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      if (reached_w || !evt_i) rel_q <= 1'b1;
    end
  end

  assign irq_o = req_i && (!en_i || rel_q);

  AST_NO_REQ_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |-> !irq_o); // R8
  AST_THRESH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && reached_w) |=> (irq_o || !req_i)); // R9
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [4:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [DW-1:0] tx_evt,
  input  logic [DW-1:0] rx_evt,
  input  logic [DW-1:0] misc_evt,
  output logic          host_irq
);
  import irq_agg_pkg::*;

  logic [NGRP-1:0][DW-1:0] evt_v, cause_v, cmode_v, mask_v, mview_v;
  logic [NGRP-1:0]         grp_pend;
  logic [NGRP-1:0]         sum_q;
  logic [DW-1:0]           smask_q;
  logic [CW-1:0]           thr_q;
  logic                    men_q;
  logic [1:0]              sel_g;
  logic [2:0]              sel_r;
  logic                    sum_rd, raw_req, evt_any;

  assign evt_v[GRP_TX]   = tx_evt;
  assign evt_v[GRP_RX]   = rx_evt;
  assign evt_v[GRP_MISC] = misc_evt;
  assign sel_g = reg_addr[4:3];
  assign sel_r = reg_addr[2:0];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic hit;
    assign hit = (sel_g == 2'(g));
    irq_cause_group #(.DW(DW)) u_grp (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt_v[g]),
      .wr_cause_i (reg_wr && hit && sel_r == OFS_CAUSE),
      .rd_cause_i (reg_rd && hit && sel_r == OFS_CAUSE),
      .wr_cmode_i (reg_wr && hit && sel_r == OFS_CMODE),
      .wr_mset_i  (reg_wr && hit && sel_r == OFS_MSET),
      .wr_mclr_i  (reg_wr && hit && sel_r == OFS_MCLR),
      .wdata_i    (reg_wdata),
      .cause_o    (cause_v[g]),
      .cmode_o    (cmode_v[g]),
      .mask_o     (mask_v[g]),
      .mview_o    (mview_v[g]),
      .pend_o     (grp_pend[g])
    );
  end

  assign sum_rd = reg_rd && reg_addr == ADR_SUM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      smask_q <= '1;
      thr_q   <= '0;
      men_q   <= 1'b0;
    end else begin
      sum_q <= sum_rd ? grp_pend : (sum_q | grp_pend);
      if (reg_wr && reg_addr == ADR_SMASK) smask_q <= reg_wdata;
      if (reg_wr && reg_addr == ADR_THR)   thr_q   <= reg_wdata[CW-1:0];
      if (reg_wr && reg_addr == ADR_MCTL)  men_q   <= reg_wdata[0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_g < 2'(NGRP)) begin
      case (sel_r)
        OFS_CAUSE: reg_rdata = cause_v[sel_g];
        OFS_CMODE: reg_rdata = cmode_v[sel_g];
        OFS_MASK:  reg_rdata = mask_v[sel_g];
        OFS_MVIEW: reg_rdata = mview_v[sel_g];
        default:   reg_rdata = '0;
      endcase
    end else begin
      case (reg_addr)
        ADR_SUM:   reg_rdata[NGRP-1:0] = sum_q;
        ADR_SMASK: reg_rdata = smask_q;
        ADR_THR:   reg_rdata[CW-1:0] = thr_q;
        ADR_MCTL:  reg_rdata[0] = men_q;
        default:   reg_rdata = '0;
      endcase
    end
  end

  assign raw_req = |(sum_q & ~smask_q[NGRP-1:0]);
  assign evt_any = |{tx_evt, rx_evt, misc_evt};

  irq_moderator #(.CW(CW)) u_mod (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (men_q),
    .thr_i (thr_q),
    .req_i (raw_req),
    .evt_i (evt_any),
    .irq_o (host_irq)
  );

  AST_SUM_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|grp_pend) |=> ((sum_q & $past(grp_pend)) == $past(grp_pend))); // R5
  AST_SMASK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ((sum_q & ~smask_q[NGRP-1:0]) == '0) |-> !host_irq); // R7
endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] tx_evt = '0, rx_evt = '0, misc_evt = '0;
  logic        host_irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t exp_q[$];
  event  smp;

  always #10 clk = ~clk;

  irq_aggregator u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_evt(tx_evt), .rx_evt(rx_evt), .misc_evt(misc_evt), .host_irq(host_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data and compares with the design
  always begin
    @(smp);
    if (exp_q.size() == 0) chk("monitor-underrun", 32'd1, 32'd0);
    else begin
      item_t it;
      it = exp_q.pop_front();
      chk(it.tag, reg_rdata, it.exp);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back('{e, tag});
    #2 ->smp;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic pulse(input int g, input logic [31:0] b);
    @(negedge clk);
    if (g == 0) tx_evt = b; else if (g == 1) rx_evt = b; else misc_evt = b;
    @(negedge clk); tx_evt = '0; rx_evt = '0; misc_evt = '0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    rd(5'd4, 32'hFFFF_FFFF, "R11 tx mask after reset");
    rd(5'd0, 32'h0, "R11 tx cause after reset");
    rd(5'd1, 32'h0, "R11 tx clear-mode after reset");
    rd(5'd25, 32'hFFFF_FFFF, "R7 summary mask after reset");
    chk("R11 host_irq low after reset", host_irq, 0);
    // masked events still latch, W1C mode ignores reads
    pulse(0, 32'h5);
    rd(5'd0, 32'h5, "R11 masked event latched");
    rd(5'd0, 32'h5, "R2 read leaves W1C bits");
    rd(5'd5, 32'h0, "R4 masked view all masked");
    rd(5'd24, 32'h0, "R5 summary idle while masked");
    // unmask a pending bit
    wr(5'd3, 32'h1);
    rd(5'd4, 32'hFFFF_FFFE, "R3 mask-clear strobe");
    rd(5'd5, 32'h1, "R4 masked view");
    rd(5'd24, 32'h1, "R12 summary after unmask of pending bit");
    chk("R7 summary mask blocks line", host_irq, 0);
    wr(5'd25, 32'hFFFF_FFF8);
    chk("R8 line high without moderation", host_irq, 1);
    // W1C clear and sticky summary
    wr(5'd0, 32'h1);
    rd(5'd0, 32'h4, "R2 write-one clears bit");
    rd(5'd24, 32'h1, "R6 summary sticky until read");
    rd(5'd24, 32'h0, "R6 summary reloaded empty");
    chk("R8 line low after summary release", host_irq, 0);
    // clear-on-read on receive group
    wr(5'd9, 32'h0000_00FF);
    wr(5'd11, 32'hFFFF_FFFF);
    pulse(1, 32'h0000_0101);
    rd(5'd8, 32'h0000_0101, "R1 first read returns value");
    rd(5'd8, 32'h0000_0100, "R1 clear-on-read bits gone");
    rd(5'd9, 32'h0000_00FF, "R1 clear-mode readback");
    rd(5'd24, 32'h2, "R5 receive summary bit");
    wr(5'd8, 32'h0000_0100);
    rd(5'd24, 32'h2, "R6 summary sticky");
    rd(5'd24, 32'h0, "R6 summary released");
    // R10 event with read-clear in same cycle
    @(negedge clk); rx_evt = 32'h1; reg_rd = 1'b1; reg_addr = 5'd8;
    exp_q.push_back('{32'h0, "R10 read during event"});
    #2 ->smp;
    @(negedge clk); rx_evt = '0; reg_rd = 1'b0;
    rd(5'd8, 32'h1, "R10 event beats read-clear");
    // R10 event with write-clear in same cycle
    @(negedge clk); tx_evt = 32'h4; reg_wr = 1'b1; reg_addr = 5'd0; reg_wdata = 32'h4;
    @(negedge clk); tx_evt = '0; reg_wr = 1'b0;
    rd(5'd0, 32'h4, "R10 event beats write-clear");
    rd(5'd24, 32'h2, "R6 summary sticky after rx release");
    rd(5'd24, 32'h0, "R6 summary empty");
    chk("R8 line low when idle", host_irq, 0);
    // mask set/clear on misc
    wr(5'd19, 32'hF);
    wr(5'd18, 32'h3);
    rd(5'd20, 32'hFFFF_FFF3, "R3 mask-set strobe");
    // moderation
    wr(5'd26, 32'd3);
    wr(5'd27, 32'd1);
    rd(5'd27, 32'd1, "R9 moderation enable readback");
    @(negedge clk); misc_evt = 32'h4;
    @(negedge clk);
    @(negedge clk);
    chk("R9 line held while burst starts", host_irq, 0);
    repeat (3) @(negedge clk);
    chk("R9 line held below threshold", host_irq, 0);
    @(negedge clk);
    chk("R9 line released at threshold", host_irq, 1);
    misc_evt = '0;
    wr(5'd16, 32'h4);
    rd(5'd24, 32'h4, "R5 misc summary bit");
    rd(5'd24, 32'h0, "R6 misc summary released");
    chk("R9 line low after clear", host_irq, 0);
    wr(5'd27, 32'd0);
    pulse(2, 32'h8);
    @(negedge clk);
    chk("R9 moderation off passes at once", host_irq, 1);
    rd(5'd21, 32'h8, "R4 misc masked view");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule